// File: doc/BRIEF.md
# Prime-Interleaved Memory Request Crossbar

This block connects a small set of requesters to 31 memory banks, each bank serving one 8-byte word per transfer. The bank is chosen from the word address (the byte address with its three low bits dropped). The word address is reduced modulo 31, and the quotient becomes the row index inside that bank. Because 31 is prime, any power-of-two stride walks through every bank before it returns to one already used. Strided vector traffic therefore spreads across the whole memory instead of piling onto a few banks.

Every requester keeps a private four-entry queue for each bank. A requester is held back only when the queue for the bank it is addressing is full, so a slow bank never delays traffic bound elsewhere. Each bank picks among the requesters with pending work in rotating order. On the way back, a bank returns the requester's tag together with the data. Responses can reach a requester in any order. When several banks answer the same requester at once, one answer is delivered per cycle and the others are held.

Top module: `pmx_xbar`

## Requirements
- R1: For a request at byte address A with word address W = A >> 3, the request reaches bank W mod 31 and carries bank_index = W div 31.
- R2: For any power-of-two word stride S (1, 2, 8, 32, 64 tested), 31 consecutive requests from one requester at W0 + k*S land on 31 distinct banks.
- R3: Each requester has a 4-entry queue per bank. req_ready for a requester is low exactly when the queue for the bank its current address maps to holds 4 entries. The fill level of queues for other banks has no effect on it.
- R4: Requests from one requester to one bank are presented at that bank in the order they were accepted.
- R5: Each bank grants the first requester, in increasing index order starting from its pointer and wrapping, that has a queued request for that bank. After an accepted transfer the pointer becomes the granted index plus one, modulo 4. All pointers are 0 after reset.
- R6: Banks operate independently. Several banks may accept requests in the same cycle. A bank holding bank_ready low keeps bank_valid high and does not stop traffic to other banks.
- R7: A bank response is delivered on the rsp port of the requester named in bresp_src, with the tag and data unchanged. Per requester, exactly one waiting bank is granted bresp_ready in any cycle where at least one is waiting. Every accepted request yields exactly one response.
- R8: While and right after reset, all queues are empty: req_ready is all ones, and bank_valid and rsp_valid are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle when valid |
| req_addr | input | NREQ x AW | Byte address per requester |
| req_we | input | NREQ | 1 = store, 0 = load |
| req_wdata | input | NREQ x DW | Store data |
| req_tag | input | NREQ x TW | Requester's tag for the response |
| bank_valid | output | NBANK | Request presented to each bank |
| bank_ready | input | NBANK | Bank accepts the presented request |
| bank_index | output | NBANK x IW | Word row inside the bank (W div 31) |
| bank_we | output | NBANK | Store flag to each bank |
| bank_wdata | output | NBANK x DW | Store data to each bank |
| bank_src | output | NBANK x SW | Index of the requester being served |
| bank_tag | output | NBANK x TW | Tag of the request being served |
| bresp_valid | input | NBANK | Bank has a response |
| bresp_ready | output | NBANK | Response taken this cycle |
| bresp_src | input | NBANK x SW | Requester the response belongs to |
| bresp_tag | input | NBANK x TW | Tag returned by the bank |
| bresp_data | input | NBANK x DW | Load data or store echo from the bank |
| rsp_valid | output | NREQ | Response delivered to requester |
| rsp_tag | output | NREQ x TW | Tag of the delivered response |
| rsp_data | output | NREQ x DW | Data of the delivered response |

## Verification
A wrong modulus fold or a wrong quotient shows up as a request that arrives at a bank where the bench has no entry queued for it. The same fault shows up on the next load response, because the bank model returns its own bank number and the received row index as data. A corrupted queue pointer or count shows up within one transfer as a tag out of order at a bank, or as a req_ready that drops or stays high against the fill the bench expects. A faulty rotating pointer shows up in the arrival order at a bank that was held stalled while several requesters filled it. A routing fault on the return path shows up in the same cycle as a tag the requester never issued, a duplicate response, or a bresp_ready pattern that is not exactly one-hot.

// File: rtl/pmx_xbar.sv
module pmx_xbar #(
  parameter int NREQ      = 4,
  parameter int BANK_BITS = 5,
  parameter int DEPTH     = 4,
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int TW        = 8,
  localparam int NBANK    = (1 << BANK_BITS) - 1,
  localparam int WAW      = AW - 3,
  localparam int IW       = WAW - BANK_BITS + 1,
  localparam int SW       = $clog2(NREQ)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NREQ-1:0]           req_valid,
  output logic [NREQ-1:0]           req_ready,
  input  logic [NREQ-1:0][AW-1:0]   req_addr,
  input  logic [NREQ-1:0]           req_we,
  input  logic [NREQ-1:0][DW-1:0]   req_wdata,
  input  logic [NREQ-1:0][TW-1:0]   req_tag,
  output logic [NBANK-1:0]          bank_valid,
  input  logic [NBANK-1:0]          bank_ready,
  output logic [NBANK-1:0][IW-1:0]  bank_index,
  output logic [NBANK-1:0]          bank_we,
  output logic [NBANK-1:0][DW-1:0]  bank_wdata,
  output logic [NBANK-1:0][SW-1:0]  bank_src,
  output logic [NBANK-1:0][TW-1:0]  bank_tag,
  input  logic [NBANK-1:0]          bresp_valid,
  output logic [NBANK-1:0]          bresp_ready,
  input  logic [NBANK-1:0][SW-1:0]  bresp_src,
  input  logic [NBANK-1:0][TW-1:0]  bresp_tag,
  input  logic [NBANK-1:0][DW-1:0]  bresp_data,
  output logic [NREQ-1:0]           rsp_valid,
  output logic [NREQ-1:0][TW-1:0]   rsp_tag,
  output logic [NREQ-1:0][DW-1:0]   rsp_data
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int NCH = (WAW + BANK_BITS - 1) / BANK_BITS;
  localparam int FW  = NCH * BANK_BITS;
  localparam int NFOLD = 4;

  function automatic logic [BANK_BITS-1:0] fold_mod(input logic [WAW-1:0] w);
    logic [FW-1:0] acc;
    logic [FW-1:0] sum;
    acc = FW'(w);
    for (int p = 0; p < NFOLD; p++) begin
      sum = '0;
      for (int c = 0; c < NCH; c++) sum = sum + FW'(acc[c*BANK_BITS +: BANK_BITS]);
      acc = sum;
    end
    return (acc[BANK_BITS-1:0] == BANK_BITS'(NBANK)) ? '0 : acc[BANK_BITS-1:0];
  endfunction

  logic [IW-1:0]        q_idx [NREQ][NBANK][DEPTH];
  logic                 q_we  [NREQ][NBANK][DEPTH];
  logic [DW-1:0]        q_dat [NREQ][NBANK][DEPTH];
  logic [TW-1:0]        q_tag [NREQ][NBANK][DEPTH];
  logic [PW-1:0]        wp    [NREQ][NBANK];
  logic [PW-1:0]        rp    [NREQ][NBANK];
  logic [CW-1:0]        cnt   [NREQ][NBANK];
  logic [SW-1:0]        rr    [NBANK];
  logic [SW-1:0]        gnt   [NBANK];
  logic [BANK_BITS-1:0] rsp_ptr [NREQ];
  logic [BANK_BITS-1:0] rsel    [NREQ];
  logic [BANK_BITS-1:0] req_bank [NREQ];
  logic [IW-1:0]        req_idx  [NREQ];
  logic                 push  [NREQ][NBANK];
  logic                 pop   [NREQ][NBANK];

  always_comb
    for (int r = 0; r < NREQ; r++) begin
      req_bank[r] = fold_mod(req_addr[r][AW-1:3]);
      req_idx[r]  = IW'(req_addr[r][AW-1:3] / NBANK);
    end

  always_comb
    for (int r = 0; r < NREQ; r++)
      req_ready[r] = (cnt[r][req_bank[r]] != CW'(DEPTH));

  always_comb
    for (int r = 0; r < NREQ; r++)
      for (int b = 0; b < NBANK; b++)
        push[r][b] = req_valid[r] && req_ready[r] && (req_bank[r] == BANK_BITS'(b));

  always_comb begin
    int i;
    for (int b = 0; b < NBANK; b++) begin
      bank_valid[b] = 1'b0;
      gnt[b] = '0;
      for (int k = 0; k < NREQ; k++) begin
        i = int'(rr[b]) + k;
        if (i >= NREQ) i = i - NREQ;
        if (!bank_valid[b] && cnt[i][b] != '0) begin
          bank_valid[b] = 1'b1;
          gnt[b] = SW'(i);
        end
      end
      bank_index[b] = q_idx[gnt[b]][b][rp[gnt[b]][b]];
      bank_we[b]    = q_we [gnt[b]][b][rp[gnt[b]][b]];
      bank_wdata[b] = q_dat[gnt[b]][b][rp[gnt[b]][b]];
      bank_tag[b]   = q_tag[gnt[b]][b][rp[gnt[b]][b]];
      bank_src[b]   = gnt[b];
    end
  end

  always_comb
    for (int r = 0; r < NREQ; r++)
      for (int b = 0; b < NBANK; b++)
        pop[r][b] = bank_valid[b] && bank_ready[b] && (gnt[b] == SW'(r));

  always_comb begin
    int i;
    for (int r = 0; r < NREQ; r++) begin
      rsp_valid[r] = 1'b0;
      rsel[r] = '0;
      for (int k = 0; k < NBANK; k++) begin
        i = int'(rsp_ptr[r]) + k;
        if (i >= NBANK) i = i - NBANK;
        if (!rsp_valid[r] && bresp_valid[i] && bresp_src[i] == SW'(r)) begin
          rsp_valid[r] = 1'b1;
          rsel[r] = BANK_BITS'(i);
        end
      end
      rsp_tag[r]  = bresp_tag[rsel[r]];
      rsp_data[r] = bresp_data[rsel[r]];
    end
  end

  always_comb
    for (int b = 0; b < NBANK; b++) begin
      bresp_ready[b] = 1'b0;
      for (int r = 0; r < NREQ; r++)
        if (rsp_valid[r] && rsel[r] == BANK_BITS'(b)) bresp_ready[b] = 1'b1;
    end

  always_ff @(posedge clk)
    for (int r = 0; r < NREQ; r++)
      for (int b = 0; b < NBANK; b++)
        if (push[r][b]) begin
          q_idx[r][b][wp[r][b]] <= req_idx[r];
          q_we [r][b][wp[r][b]] <= req_we[r];
          q_dat[r][b][wp[r][b]] <= req_wdata[r];
          q_tag[r][b][wp[r][b]] <= req_tag[r];
        end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREQ; r++) begin
        rsp_ptr[r] <= '0;
        for (int b = 0; b < NBANK; b++) begin
          wp[r][b]  <= '0;
          rp[r][b]  <= '0;
          cnt[r][b] <= '0;
        end
      end
      for (int b = 0; b < NBANK; b++) rr[b] <= '0;
    end else begin
      for (int r = 0; r < NREQ; r++) begin
        if (rsp_valid[r])
          rsp_ptr[r] <= (rsel[r] == BANK_BITS'(NBANK - 1)) ? '0 : rsel[r] + 1'b1;
        for (int b = 0; b < NBANK; b++) begin
          if (push[r][b]) wp[r][b] <= (wp[r][b] == PW'(DEPTH - 1)) ? '0 : wp[r][b] + 1'b1;
          if (pop[r][b])  rp[r][b] <= (rp[r][b] == PW'(DEPTH - 1)) ? '0 : rp[r][b] + 1'b1;
          cnt[r][b] <= cnt[r][b] + CW'(push[r][b]) - CW'(pop[r][b]);
        end
      end
      for (int b = 0; b < NBANK; b++)
        if (bank_valid[b] && bank_ready[b])
          rr[b] <= (gnt[b] == SW'(NREQ - 1)) ? '0 : gnt[b] + 1'b1;
    end
  end
endmodule

// File: rtl/pmx_xbar_chk.sv
module pmx_xbar_chk #(
  parameter int NREQ      = 4,
  parameter int BANK_BITS = 5,
  parameter int AW        = 32,
  localparam int NBANK    = (1 << BANK_BITS) - 1,
  localparam int SW       = $clog2(NREQ)
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NREQ-1:0]          req_valid,
  input logic [NREQ-1:0]          req_ready,
  input logic [NREQ-1:0][AW-1:0]  req_addr,
  input logic [BANK_BITS-1:0]     req_bank [NREQ],
  input logic [NBANK-1:0]         bank_valid,
  input logic [NBANK-1:0]         bank_ready,
  input logic [NBANK-1:0]         bresp_valid,
  input logic [NBANK-1:0]         bresp_ready,
  input logic [NBANK-1:0][SW-1:0] bresp_src,
  input logic [NREQ-1:0]          rsp_valid
);
  logic [NBANK-1:0] mine [NREQ];

  always_comb
    for (int r = 0; r < NREQ; r++)
      for (int b = 0; b < NBANK; b++)
        mine[r][b] = bresp_valid[b] && (bresp_src[b] == SW'(r));

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bank_valid == '0) && (req_ready == '1) && (rsp_valid == '0));

  // R7
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (bresp_ready & ~bresp_valid) == '0);

  for (genvar r = 0; r < NREQ; r++) begin : g_req
    // R1
    bank_map_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid[r] |-> (req_bank[r] == BANK_BITS'(req_addr[r][AW-1:3] % NBANK)));
    // R7
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(bresp_ready & mine[r]));
    // R7
    rsp_served_chk: assert property (@(posedge clk) disable iff (rst)
      (mine[r] != '0) |-> rsp_valid[r] && ((bresp_ready & mine[r]) != '0));
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      bank_valid[b] && !bank_ready[b] |=> bank_valid[b]);
  end
endmodule

bind pmx_xbar pmx_xbar_chk #(.NREQ(NREQ), .BANK_BITS(BANK_BITS), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_bank(req_bank), .bank_valid(bank_valid),
  .bank_ready(bank_ready), .bresp_valid(bresp_valid), .bresp_ready(bresp_ready),
  .bresp_src(bresp_src), .rsp_valid(rsp_valid));

// File: tb/pmx_xbar_tb_top.sv
module pmx_xbar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4, BB = 5, NB = 31, AW = 32, DW = 64, TW = 8;
  localparam int IW = AW - 3 - BB + 1, SW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [NR-1:0] req_valid, req_ready, req_we, rsp_valid;
  logic [NR-1:0][AW-1:0] req_addr;
  logic [NR-1:0][DW-1:0] req_wdata, rsp_data;
  logic [NR-1:0][TW-1:0] req_tag, rsp_tag;
  logic [NB-1:0] bank_valid, bank_ready, bank_we, bresp_valid, bresp_ready;
  logic [NB-1:0][IW-1:0] bank_index;
  logic [NB-1:0][DW-1:0] bank_wdata, bresp_data;
  logic [NB-1:0][SW-1:0] bank_src, bresp_src;
  logic [NB-1:0][TW-1:0] bank_tag, bresp_tag;

  pmx_xbar dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int word; logic we; logic [DW-1:0] d; logic [TW-1:0] tag; } req_t;
  typedef struct { int word; logic [TW-1:0] tag; } ord_t;
  typedef struct { int src; logic [TW-1:0] tag; logic [DW-1:0] d; int due; } pend_t;

  req_t  stim_q [NR][$];
  ord_t  ord_q  [NR][NB][$];
  pend_t pend_q [NB][$];
  logic [DW-1:0] exp_d [NR][int];
  int lat [NB];
  logic stall [NB];
  int tag_ctr [NR];
  int hist0 [NB];
  int arr_bank [NB];
  int arr7_src [$];
  int cyc = 0, max_conc = 0;
  int vectors = 0, misses = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic send(input int r, input int word, input logic we, input logic [DW-1:0] d);
    req_t q;
    q.word = word; q.we = we; q.d = d; q.tag = TW'(tag_ctr[r]);
    tag_ctr[r]++;
    stim_q[r].push_back(q);
    exp_d[r][int'(q.tag)] = we ? d : {32'(word % NB), 32'(word / NB)};
  endtask

  task automatic step();
    int conc;
    @(negedge clk);
    cyc++;
    for (int r = 0; r < NR; r++) begin
      req_valid[r] = stim_q[r].size() > 0;
      if (req_valid[r]) begin
        req_addr[r] = AW'(stim_q[r][0].word) << 3;
        req_we[r] = stim_q[r][0].we; req_wdata[r] = stim_q[r][0].d; req_tag[r] = stim_q[r][0].tag;
      end
    end
    for (int b = 0; b < NB; b++) begin
      bank_ready[b] = !stall[b];
      bresp_valid[b] = pend_q[b].size() > 0 && pend_q[b][0].due <= cyc;
      if (bresp_valid[b]) begin
        bresp_src[b] = SW'(pend_q[b][0].src); bresp_tag[b] = pend_q[b][0].tag; bresp_data[b] = pend_q[b][0].d;
      end
    end
    #1;
    for (int r = 0; r < NR; r++)
      if (req_valid[r] && req_ready[r]) begin
        ord_t o;
        o.word = stim_q[r][0].word; o.tag = stim_q[r][0].tag;
        ord_q[r][o.word % NB].push_back(o);
        void'(stim_q[r].pop_front());
      end
    conc = 0;
    for (int b = 0; b < NB; b++)
      if (bank_valid[b] && bank_ready[b]) begin
        int s;
        pend_t p;
        s = int'(bank_src[b]);
        conc++;
        arr_bank[b]++;
        if (s == 0) hist0[b]++;
        if (b == 7) arr7_src.push_back(s);
        if (ord_q[s][b].size() == 0) chk(0, "R1", "request at unexpected bank", b, 0);
        else begin
          ord_t o;
          o = ord_q[s][b].pop_front();
          // R4 order within one requester/bank queue
          chk(bank_tag[b] == o.tag, "R4", "tag order at bank", bank_tag[b], o.tag);
          // R1 row index inside the bank
          chk(int'(bank_index[b]) == o.word / NB, "R1", "bank_index", bank_index[b], o.word / NB);
        end
        p.src = s; p.tag = bank_tag[b]; p.due = cyc + lat[b];
        p.d = bank_we[b] ? bank_wdata[b] : {32'(b), 32'(bank_index[b])};
        pend_q[b].push_back(p);
      end
    if (conc > max_conc) max_conc = conc;
    for (int r = 0; r < NR; r++) begin
      int nv, ng;
      nv = 0; ng = 0;
      for (int b = 0; b < NB; b++)
        if (bresp_valid[b] && int'(bresp_src[b]) == r) begin
          nv++;
          if (bresp_ready[b]) ng++;
        end
      if (nv > 0 || rsp_valid[r]) begin
        // R7 one grant per requester, and only when something waits
        chk(ng == 1 && rsp_valid[r] && nv > 0, "R7", "grant count", ng, 1);
        if (rsp_valid[r]) begin
          if (exp_d[r].exists(int'(rsp_tag[r]))) begin
            chk(rsp_data[r] == exp_d[r][int'(rsp_tag[r])], "R7", "response data", rsp_data[r], exp_d[r][int'(rsp_tag[r])]);
            exp_d[r].delete(int'(rsp_tag[r]));
          end else chk(0, "R7", "unexpected or duplicate tag", rsp_tag[r], 0);
        end
      end
    end
    for (int b = 0; b < NB; b++)
      if (bresp_valid[b] && bresp_ready[b]) void'(pend_q[b].pop_front());
  endtask

  function automatic bit idle();
    for (int r = 0; r < NR; r++) begin
      if (stim_q[r].size() != 0) return 0;
      for (int b = 0; b < NB; b++) if (ord_q[r][b].size() != 0) return 0;
    end
    for (int b = 0; b < NB; b++) if (pend_q[b].size() != 0) return 0;
    return 1;
  endfunction

  task automatic drain();
    int n;
    n = 0;
    while (!idle() && n < 4000) begin step(); n++; end
    if (!idle()) chk(0, "R7", "drain timeout", n, 0);
    for (int r = 0; r < NR; r++)
      chk(exp_d[r].size() == 0, "R7", "missing responses", exp_d[r].size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int seq [5];
    int strides [5];
    req_valid = '0; req_addr = '0; req_we = '0; req_wdata = '0; req_tag = '0;
    bank_ready = '0; bresp_valid = '0; bresp_src = '0; bresp_tag = '0; bresp_data = '0;
    for (int b = 0; b < NB; b++) begin lat[b] = 1 + $urandom_range(0, 6); stall[b] = 0; arr_bank[b] = 0; end
    for (int r = 0; r < NR; r++) tag_ctr[r] = 0;
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    chk(req_ready == '1, "R8", "req_ready in reset", req_ready, 4'hf);
    chk(bank_valid == '0, "R8", "bank_valid in reset", bank_valid, 0);
    chk(rsp_valid == '0, "R8", "rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;

    // R5 rotating grant from a reset pointer
    stall[7] = 1;
    send(0, 7, 0, 0); send(0, 7 + NB, 0, 0); send(1, 7 + 2*NB, 1, 64'h1111);
    send(3, 7 + 3*NB, 0, 0); send(3, 7 + 4*NB, 1, 64'h3333);
    repeat (6) step();
    chk(bank_valid[7] == 1'b1, "R6", "stalled bank keeps valid", bank_valid[7], 1);
    stall[7] = 0;
    drain();
    seq = '{0, 1, 3, 0, 3};
    chk(arr7_src.size() == 5, "R5", "arrivals at bank 7", arr7_src.size(), 5);
    for (int i = 0; i < 5 && i < arr7_src.size(); i++)
      chk(arr7_src[i] == seq[i], "R5", "round-robin order", arr7_src[i], seq[i]);

    // R3 / R6 full queue blocks only its own bank
    stall[5] = 1;
    for (int k = 0; k < 4; k++) send(1, 5 + k*NB, 1, 64'(k + 100));
    repeat (6) step();
    chk(stim_q[1].size() == 0, "R3", "four entries accepted", stim_q[1].size(), 0);
    send(1, 5 + 4*NB, 1, 64'h55);
    send(2, 6 + 9*NB, 0, 0);
    arr_bank[6] = 0;
    repeat (3) step();
    chk(req_ready[1] == 1'b0, "R3", "ready low on full queue", req_ready[1], 0);
    chk(stim_q[1].size() == 1, "R3", "fifth request held", stim_q[1].size(), 1);
    chk(arr_bank[6] == 1, "R6", "other bank served during stall", arr_bank[6], 1);
    begin
      req_t h;
      h = stim_q[1].pop_back();
      exp_d[1].delete(int'(h.tag));
    end
    send(1, 6 + 10*NB, 0, 0);
    step();
    chk(stim_q[1].size() == 0, "R3", "other bank accepted from same requester", stim_q[1].size(), 0);
    stall[5] = 0;
    drain();

    // R2 power-of-two strides with concurrent traffic
    strides = '{1, 2, 8, 32, 64};
    for (int si = 0; si < 5; si++) begin
      int s, bad;
      s = strides[si];
      for (int b = 0; b < NB; b++) hist0[b] = 0;
      for (int k = 0; k < NB; k++) begin
        send(0, 3 + k*s, 0, 0);
        send(1, 5000 + k*s, 1, {32'(k), 32'(s)});
        send(2, 9001 + k*s, 0, 0);
        send(3, 13007 + k*s, 1, {$urandom(), $urandom()});
      end
      drain();
      bad = 0;
      for (int b = 0; b < NB; b++) if (hist0[b] != 1) bad++;
      chk(bad == 0, "R2", $sformatf("banks hit once for stride %0d", s), bad, 0);
    end
    chk(max_conc >= 2, "R6", "parallel bank accepts", max_conc, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule